// File: doc/BRIEF.md
# Flash Program/Erase Mode Register

This block is the CPU-visible control register for an on-chip 8 KB flash array. Software uses it to select a program operation, a page erase or a whole-array erase, and then to enable the high voltage. The register has four implemented bits: program select, erase select, whole-array select and high-voltage enable. Every write passes through hardware interlocks, so an illegal bit combination cannot be stored.

A write into the flash window, other than to the register itself, latches the target address while the high voltage is off. From this latched address the block drives the base address of the 64-byte erase page. A rise of the high-voltage enable produces a one-cycle start pulse for the array sequencer. The 34-byte interrupt-vector area at the top of memory may only be erased as part of a whole-array erase. If a single-page erase targets that area, the block raises an error flag and withholds high voltage from the array.

Top module: `flash_ctl`

## Requirements
- R1: After reset, the register reads 0x00, and pgmMode, eraseMode, massMode, hvDrive, opStart, vecErr and pageBase are all 0.
- R2: A read at REG_ADDR (0xFE08) returns {4'b0, hv, mass, erase, pgm}, with hv at bit 3, mass at bit 2, erase at bit 1 and pgm at bit 0. Writes to bits 7..4 are discarded. When busRd is low, busRdData is 0.
- R3: A register write that has both bit 1 and bit 0 set leaves the stored pgm and erase bits at their previous values, so pgmMode and eraseMode are never 1 together.
- R4: A write of 1 to bit 3 sets hv only if pgm or erase was already 1 before that write. Otherwise bit 3 is ignored and the other bits are written.
- R5: A write that leaves both pgm and erase at 0 also clears hv in the same write.
- R6: A bus write at an address at or above FLASH_BASE (0xE000), other than REG_ADDR, latches the address while hv is 0. pageBase shows the latched address with its low 6 bits cleared. Writes below FLASH_BASE do not change the latch.
- R7: While hv is 1, array writes do not change the latched address or pageBase.
- R8: opStart is high for exactly one cycle, in the cycle after the write that takes hv from 0 to 1, unless the request is refused under R9.
- R9: While hv=1, erase=1, mass=0 and the latched address is at or above VEC_BASE (0xFFDE), vecErr is 1, hvDrive is 0 and opStart stays 0. An address of 0xFFDD is not refused.
- R10: hvDrive is 1 whenever hv is 1 and the request is not refused, including a whole-array erase with the latch in the vector area and a program operation there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 16 | CPU bus address |
| busWrData | input | 8 | CPU write data |
| busWr | input | 1 | Write strobe, one cycle per write |
| busRd | input | 1 | Read strobe |
| busRdData | output | 8 | Register read data, 0 when not selected |
| pgmMode | output | 1 | Program operation selected |
| eraseMode | output | 1 | Erase operation selected |
| massMode | output | 1 | Whole-array erase selected (0 = single page) |
| hvDrive | output | 1 | High voltage to the array |
| opStart | output | 1 | One-cycle start pulse on the high-voltage rise |
| vecErr | output | 1 | Page erase of the vector area refused |
| pageBase | output | 16 | Latched address with low 6 bits cleared |

## Verification
The refused vector-page erase is the hardest case to reach. It needs three steps in order: an array write into the last 34 bytes while hv is still 0, then a write that selects erase alone, then a separate write that raises hv. The bench runs this sequence at addresses just inside and just outside the vector boundary. It then sets the whole-array bit while hv stays high, to show that the refusal lifts without a second start pulse.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;
  // Bus decode strobes passed from control to datapath
  typedef struct packed {
    logic regWr;
    logic regRd;
    logic arrWr;
  } busStrobe_t;

  // Stored mode bits; packed order matches read-back bit positions 3..0
  typedef struct packed {
    logic hv;
    logic mass;
    logic erase;
    logic pgm;
  } modeBits_t;

  localparam int MODE_W = 4;
endpackage

// File: rtl/flash_ctl_decode.sv
module flash_ctl_decode #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFE08,
  parameter logic [ADDR_W-1:0] FLASH_BASE = 16'hE000
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic busWr,
  input  logic busRd,
  input  logic hvActive,
  output flash_ctl_pkg::busStrobe_t strobe
);
  logic hitReg;
  logic inWindow;

  assign hitReg = (busAddr == REG_ADDR);
  assign inWindow = (busAddr >= FLASH_BASE);

  always_comb begin
    strobe.regWr = busWr && hitReg;
    strobe.regRd = busRd && hitReg;
    // the target address is frozen once high voltage is on
    strobe.arrWr = busWr && inWindow && !hitReg && !hvActive;
  end
endmodule

// File: rtl/flash_ctl_pagechk.sv
module flash_ctl_pagechk #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 6,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFDE
) (
  input  logic [ADDR_W-1:0] latchAddr,
  input  flash_ctl_pkg::modeBits_t mode,
  output logic [ADDR_W-1:0] pageBase,
  output logic refuse
);
  logic inVec;

  assign pageBase = {latchAddr[ADDR_W-1:PAGE_W], {PAGE_W{1'b0}}};
  assign inVec = (latchAddr >= VEC_BASE);
  assign refuse = mode.hv && mode.erase && !mode.mass && inVec;
endmodule

// File: rtl/flash_ctl_regs.sv
module flash_ctl_regs #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic clk,
  input  logic rstN,
  input  flash_ctl_pkg::busStrobe_t strobe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic refuse,
  output flash_ctl_pkg::modeBits_t mode,
  output logic [ADDR_W-1:0] latchAddr,
  output logic [DATA_W-1:0] rdData,
  output logic startPulse
);
  import flash_ctl_pkg::*;

  modeBits_t wrBits;
  modeBits_t modeNext;
  logic hvPrev;
  logic keepPair;

  assign wrBits = busWrData[MODE_W-1:0];
  assign keepPair = wrBits.pgm && wrBits.erase;

  always_comb begin
    modeNext = mode;
    if (strobe.regWr) begin
      modeNext.mass = wrBits.mass;
      if (!keepPair) begin
        modeNext.pgm = wrBits.pgm;
        modeNext.erase = wrBits.erase;
      end
      modeNext.hv = wrBits.hv && (modeNext.pgm || modeNext.erase) &&
                    (mode.hv || mode.pgm || mode.erase);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode <= '0;
      latchAddr <= '0;
      hvPrev <= 1'b0;
    end else begin
      mode <= modeNext;
      hvPrev <= mode.hv;
      if (strobe.arrWr) latchAddr <= busAddr;
    end
  end

  assign startPulse = mode.hv && !hvPrev && !refuse;
  assign rdData = strobe.regRd ? {{(DATA_W-MODE_W){1'b0}}, mode} : '0;
endmodule

// File: rtl/flash_ctl.sv
module flash_ctl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 6,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFE08,
  parameter logic [ADDR_W-1:0] FLASH_BASE = 16'hE000,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFDE
) (
  input  logic clk,
  input  logic rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic busWr,
  input  logic busRd,
  output logic [DATA_W-1:0] busRdData,
  output logic pgmMode,
  output logic eraseMode,
  output logic massMode,
  output logic hvDrive,
  output logic opStart,
  output logic vecErr,
  output logic [ADDR_W-1:0] pageBase
);
  import flash_ctl_pkg::*;

  busStrobe_t strobe;
  modeBits_t mode;
  logic [ADDR_W-1:0] latchAddr;
  logic refuse;

  flash_ctl_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .FLASH_BASE(FLASH_BASE)) u_decode (
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .hvActive(mode.hv), .strobe(strobe)
  );

  flash_ctl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busAddr(busAddr),
    .busWrData(busWrData), .refuse(refuse), .mode(mode),
    .latchAddr(latchAddr), .rdData(busRdData), .startPulse(opStart)
  );

  flash_ctl_pagechk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .VEC_BASE(VEC_BASE)) u_page (
    .latchAddr(latchAddr), .mode(mode), .pageBase(pageBase), .refuse(refuse)
  );

  assign pgmMode = mode.pgm;
  assign eraseMode = mode.erase;
  assign massMode = mode.mass;
  assign hvDrive = mode.hv && !refuse;
  assign vecErr = refuse;
endmodule

// File: rtl/flash_ctl_chk.sv
module flash_ctl_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic clk,
  input logic rstN,
  input logic busRd,
  input logic [DATA_W-1:0] busRdData,
  input logic pgmMode,
  input logic eraseMode,
  input logic hvDrive,
  input logic opStart,
  input logic vecErr,
  input logic [ADDR_W-1:0] pageBase
);
  // R3: program and erase never selected together
  a_r3_mode_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(pgmMode && eraseMode));

  // R4: high voltage only with a mode selected
  a_r4_hv_needs_mode: assert property (@(posedge clk) disable iff (!rstN)
    hvDrive |-> (pgmMode || eraseMode));

  // R2: idle read bus is zero
  a_r2_idle_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |-> (busRdData == '0));

  // R8: start is a single-cycle pulse
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    opStart |=> !opStart);

  // R9: refusal withholds voltage and start
  a_r9_refuse_quiet: assert property (@(posedge clk) disable iff (!rstN)
    vecErr |-> (!hvDrive && !opStart));

  // R7: page base frozen while high voltage is on
  a_r7_latch_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (hvDrive || vecErr) |=> $stable(pageBase));
endmodule

bind flash_ctl flash_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .busRd(busRd), .busRdData(busRdData),
  .pgmMode(pgmMode), .eraseMode(eraseMode), .hvDrive(hvDrive),
  .opStart(opStart), .vecErr(vecErr), .pageBase(pageBase)
);

// File: tb/flash_ctl_tb.sv
module flash_ctl_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] REG = 16'hFE08;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic busWr = 1'b0;
  logic busRd = 1'b0;
  logic [7:0] busRdData;
  logic pgmMode, eraseMode, massMode, hvDrive, opStart, vecErr;
  logic [15:0] pageBase;

  int nChecks = 0;
  int nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_ctl u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWr(busWr), .busRd(busRd), .busRdData(busRdData),
    .pgmMode(pgmMode), .eraseMode(eraseMode), .massMode(massMode),
    .hvDrive(hvDrive), .opStart(opStart), .vecErr(vecErr), .pageBase(pageBase)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0; busAddr = '0; busWrData = '0;
  endtask

  task automatic regRead(output logic [7:0] d);
    @(negedge clk);
    busAddr = REG; busRd = 1'b1;
    #1 d = busRdData;
    busRd = 1'b0; busAddr = '0;
  endtask

  task automatic clearAll();
    busWrite(REG, 8'h00);
    busWrite(REG, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    regRead(d);
    check("R1 reg", {8'h0, d}, 16'h0000);
    check("R1 outs", {10'h0, pgmMode, eraseMode, massMode, hvDrive, opStart, vecErr}, 16'h0);
    check("R1 pageBase", pageBase, 16'h0000);
  endtask

  task automatic t_readFormat();
    logic [7:0] d;
    busWrite(REG, 8'h04);
    regRead(d);
    check("R2 mass bit2", {8'h0, d}, 16'h0004);
    busWrite(REG, 8'hF1);
    regRead(d);
    check("R2 upper bits dropped", {8'h0, d}, 16'h0001);
    @(negedge clk);
    busAddr = REG; #1;
    check("R2 no read strobe", {8'h0, busRdData}, 16'h0000);
    busAddr = '0;
    clearAll();
  endtask

  task automatic t_interlock();
    logic [7:0] d;
    busWrite(REG, 8'h01);
    busWrite(REG, 8'h03);
    regRead(d);
    check("R3 keep pgm", {8'h0, d}, 16'h0001);
    busWrite(REG, 8'h02);
    busWrite(REG, 8'h03);
    regRead(d);
    check("R3 keep erase", {8'h0, d}, 16'h0002);
    busWrite(REG, 8'h00);
    busWrite(REG, 8'h03);
    regRead(d);
    check("R3 keep zero", {8'h0, d}, 16'h0000);
  endtask

  task automatic t_hvGate();
    logic [7:0] d;
    busWrite(16'hE040, 8'h55);
    busWrite(REG, 8'h09);
    check("R4 no start when gated", {15'h0, opStart}, 16'h0);
    regRead(d);
    check("R4 hv ignored", {8'h0, d}, 16'h0001);
    busWrite(REG, 8'h09);
    check("R8 start pulse", {15'h0, opStart}, 16'h1);
    check("R10 hvDrive program", {15'h0, hvDrive}, 16'h1);
    @(negedge clk);
    check("R8 pulse ends", {15'h0, opStart}, 16'h0);
    regRead(d);
    check("R4 hv set", {8'h0, d}, 16'h0009);
    busWrite(REG, 8'h08);
    regRead(d);
    check("R5 hv cleared with mode", {8'h0, d}, 16'h0000);
    check("R5 hvDrive low", {15'h0, hvDrive}, 16'h0);
  endtask

  task automatic t_latch();
    busWrite(16'hE123, 8'hAA);
    check("R6 page base", pageBase, 16'hE100);
    busWrite(16'hF0C5, 8'hAA);
    check("R6 page base 2", pageBase, 16'hF0C0);
    busWrite(16'h1234, 8'hAA);
    check("R6 outside window", pageBase, 16'hF0C0);
    busWrite(REG, 8'h01);
    check("R6 register write no latch", pageBase, 16'hF0C0);
    busWrite(REG, 8'h09);
    busWrite(16'hE000, 8'hAA);
    check("R7 frozen under hv", pageBase, 16'hF0C0);
    clearAll();
    busWrite(16'hE000, 8'hAA);
    check("R7 unfrozen after hv off", pageBase, 16'hE000);
  endtask

  task automatic t_vector();
    busWrite(16'hFFE0, 8'h00);
    busWrite(REG, 8'h02);
    busWrite(REG, 8'h0A);
    check("R9 vecErr", {15'h0, vecErr}, 16'h1);
    check("R9 no start", {15'h0, opStart}, 16'h0);
    check("R9 no hvDrive", {15'h0, hvDrive}, 16'h0);
    busWrite(REG, 8'h0E);
    check("R10 mass lifts refusal", {14'h0, vecErr, hvDrive}, 16'h1);
    check("R8 no second pulse", {15'h0, opStart}, 16'h0);
    clearAll();
    busWrite(REG, 8'h06);
    busWrite(REG, 8'h0E);
    check("R10 mass erase start", {14'h0, opStart, vecErr}, 16'h2);
    clearAll();
    busWrite(16'hFFDD, 8'h00);
    busWrite(REG, 8'h02);
    busWrite(REG, 8'h0A);
    check("R9 boundary below", {14'h0, vecErr, opStart}, 16'h1);
    clearAll();
    busWrite(16'hFFDE, 8'h00);
    busWrite(REG, 8'h02);
    busWrite(REG, 8'h0A);
    check("R9 boundary at base", {14'h0, vecErr, hvDrive}, 16'h2);
    clearAll();
    busWrite(16'hFFF0, 8'h00);
    busWrite(REG, 8'h01);
    busWrite(REG, 8'h09);
    check("R10 program in vector area", {13'h0, vecErr, hvDrive, opStart}, 16'h3);
    clearAll();
  endtask

  logic done = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_readFormat();
    t_interlock();
    t_hvGate();
    t_latch();
    t_vector();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule